// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns an interrupt request's addressing information into a bitmask with one bit per agent. The agents are the interrupt targets of a multi-agent system, and their number is set by `N_AGENTS`. The block keeps a small table with one entry per agent. An entry holds the agent's short 8-bit identifier and its 32-bit extended identifier. It also holds an 8-bit logical identifier, a flag that picks between the flat and clustered logical models, a flag for extended addressing mode, and a flag that marks the slot as populated. Software or a configuration engine fills this table through a single-entry write port.

A request carries several fields:
- a 32-bit destination;
- a physical/logical addressing flag;
- a 2-bit shorthand;
- the index of the sending agent;
- a lowest-priority option.

The block matches the destination against every entry in parallel. Each entry is matched under the rules of its own mode. The block then applies broadcast and shorthand overrides. When the lowest-priority option is set, it keeps only one target. The resulting mask is registered and marked valid one clock after the request strobe. The block does not inject interrupts.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_mask` is all zeros.
- R2: A request sampled with `req_valid`=1 on a rising edge gives `out_valid`=1 and its mask after that same edge. On an edge with `req_valid`=0, `out_valid` goes to 0 and `out_mask` keeps its previous value.
- R3: With shorthand 0, `req_logical`=0 and destination 0xFFFFFFFF, every bit of the mask is set, including the bits of agents whose populated flag is clear.
- R4: In physical mode (`req_logical`=0), a populated agent in extended mode matches when its 32-bit extended identifier equals the full destination. A populated agent that is not in extended mode matches when its 8-bit identifier equals destination bits 7:0. Unpopulated agents never match.
- R5: In physical mode, a destination equal to exactly 0x000000FF also selects every populated agent that is not in extended mode.
- R6: In logical mode (`req_logical`=1), a destination of 0xFFFFFFFF selects every populated extended-mode agent. Agents that are not in extended mode are still matched by the ordinary logical rules (R8, R9).
- R7: In logical mode, a populated extended-mode agent matches when destination bits 31:16 equal bits 31:16 of its extended identifier, and the AND of destination bits 15:0 with identifier bits 15:0 is nonzero.
- R8: In logical mode, a populated agent with `cfg_cluster`=0 (flat model) matches when destination bits 7:0 ANDed with its logical identifier is nonzero.
- R9: In logical mode, a populated agent with `cfg_cluster`=1 matches under these conditions:
  - destination bits 7:4 equal its logical identifier bits 7:4, or equal 0xF (the all-clusters value);
  - destination bits 3:0 ANDed with identifier bits 3:0 is nonzero.
- R10: Shorthand 1 selects only the sender. Shorthand 2 selects every agent. Shorthand 3 selects every agent except the sender. In each case only populated agents are selected, and the destination and addressing flag have no effect.
- R11: With `req_lowest`=1, only the lowest-indexed set bit of the mask that would otherwise be produced is kept. An empty mask stays empty.
- R12: With `cfg_we`=1 on a rising edge, the entry at `cfg_idx` is written. A request sampled on the same edge still sees the old entry, and requests on later edges see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_phys_id | input | 8 | Short identifier |
| cfg_ext_id | input | 32 | Extended identifier (physical match and 16/16 logical cluster) |
| cfg_log_id | input | 8 | Logical identifier |
| cfg_cluster | input | 1 | 1 = clustered logical model, 0 = flat |
| cfg_ext | input | 1 | 1 = agent in extended addressing mode |
| cfg_present | input | 1 | 1 = slot populated |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 32 | Destination |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 lookup, 1 self, 2 all, 3 all but self |
| req_sender | input | IDX_W | Index of the sending agent |
| req_lowest | input | 1 | Keep only the lowest-indexed target |
| out_valid | output | 1 | Mask valid for one cycle |
| out_mask | output | N_AGENTS | Delivery bitmask, bit i = agent i |

## Verification
The hardest situations to reach are the ones where two rule sets apply to the same destination at once. One example is the logical all-ones value: extended-mode agents take it as a broadcast, while clustered agents read it as cluster 0xF with a full member mask. Another is the physical value 0xFF, which legacy agents take as a broadcast but extended agents compare literally.

The bench builds a 16-entry table that mixes every mode. It includes unpopulated slots and extended identifiers given to legacy agents to act as decoys. It then sweeps all 256 low-byte destinations in both addressing modes, with and without the lowest-priority option. The table write is checked by writing an entry and issuing a matching request on the same edge, then again on the next edge.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

   typedef struct packed {
      logic        present;
      logic        ext;
      logic        cluster;
      logic [7:0]  phys_id;
      logic [7:0]  log_id;
      logic [31:0] ext_id;
   } agent_t;

   typedef enum logic [1:0] {
      SH_LOOKUP   = 2'd0,
      SH_SELF     = 2'd1,
      SH_ALL      = 2'd2,
      SH_ALL_BUT  = 2'd3
   } shorthand_e;

endpackage

// File: rtl/irq_dest_table.sv
module irq_dest_table
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS = 16,
   localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  agent_t           wr_entry,
   output agent_t           entries [N_AGENTS]
);

   for (genvar g = 0; g < N_AGENTS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            entries[g] <= wr_entry;
         end
      end
   end

endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
   import irq_dest_pkg::*;
(
   input  agent_t      agent,
   input  logic [31:0] dest,
   input  logic        logical,
   output logic        hit
);

   logic all_ones;
   logic cl_ok;

   always_comb begin
      all_ones = (dest == 32'hFFFF_FFFF);
      cl_ok    = (dest[7:4] == 4'hF) || (dest[7:4] == agent.log_id[7:4]);
      hit      = 1'b0;
      if (!logical) begin
         if (agent.ext) begin
            hit = (agent.ext_id == dest);
         end else begin
            hit = (agent.phys_id == dest[7:0]) || (dest == 32'h0000_00FF);
         end
      end else begin
         if (agent.ext) begin
            hit = all_ones ||
                  ((dest[31:16] == agent.ext_id[31:16]) &&
                   (|(dest[15:0] & agent.ext_id[15:0])));
         end else if (agent.cluster) begin
            hit = cl_ok && (|(dest[3:0] & agent.log_id[3:0]));
         end else begin
            hit = |(dest[7:0] & agent.log_id);
         end
      end
      hit = hit && agent.present;
   end

endmodule

// File: rtl/irq_dest_lowest.sv
module irq_dest_lowest #(
   parameter int N_AGENTS    = 16,
   parameter int LOWEST_IMPL = 0
) (
   input  logic [N_AGENTS-1:0] mask_in,
   output logic [N_AGENTS-1:0] mask_out
);

   if (LOWEST_IMPL == 0) begin : g_arith
      always_comb mask_out = mask_in & (~mask_in + N_AGENTS'(1));
   end else begin : g_ripple
      logic [N_AGENTS:0] seen;
      always_comb begin
         seen[0] = 1'b0;
         for (int i = 0; i < N_AGENTS; i++) begin
            mask_out[i] = mask_in[i] && !seen[i];
            seen[i+1]   = seen[i] || mask_in[i];
         end
      end
   end

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
   import irq_dest_pkg::*;
#(
   parameter int N_AGENTS    = 16,
   parameter int LOWEST_IMPL = 0,
   localparam int IDX_W      = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [7:0]          cfg_phys_id,
   input  logic [31:0]         cfg_ext_id,
   input  logic [7:0]          cfg_log_id,
   input  logic                cfg_cluster,
   input  logic                cfg_ext,
   input  logic                cfg_present,
   input  logic                req_valid,
   input  logic [31:0]         req_dest,
   input  logic                req_logical,
   input  logic [1:0]          req_shorthand,
   input  logic [IDX_W-1:0]    req_sender,
   input  logic                req_lowest,
   output logic                out_valid,
   output logic [N_AGENTS-1:0] out_mask
);

   if (N_AGENTS < 2 || N_AGENTS > 256) begin : g_bad_count
      $error("irq_dest_resolver: N_AGENTS must lie in 2..256");
   end
   if (LOWEST_IMPL != 0 && LOWEST_IMPL != 1) begin : g_bad_impl
      $error("irq_dest_resolver: LOWEST_IMPL must be 0 or 1");
   end

   agent_t              entries [N_AGENTS];
   agent_t              wr_entry;
   logic [N_AGENTS-1:0] hits;
   logic [N_AGENTS-1:0] present_v;
   logic [N_AGENTS-1:0] sender_oh;
   logic [N_AGENTS-1:0] lookup_mask;
   logic [N_AGENTS-1:0] raw_mask;
   logic [N_AGENTS-1:0] low_mask;
   logic                phys_bcast;

   always_comb begin
      wr_entry.present = cfg_present;
      wr_entry.ext     = cfg_ext;
      wr_entry.cluster = cfg_cluster;
      wr_entry.phys_id = cfg_phys_id;
      wr_entry.log_id  = cfg_log_id;
      wr_entry.ext_id  = cfg_ext_id;
   end

   irq_dest_table #(.N_AGENTS(N_AGENTS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_idx   (cfg_idx),
      .wr_entry (wr_entry),
      .entries  (entries)
   );

   for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
      irq_dest_match u_match (
         .agent   (entries[g]),
         .dest    (req_dest),
         .logical (req_logical),
         .hit     (hits[g])
      );
      assign present_v[g] = entries[g].present;
   end

   always_comb begin
      phys_bcast  = !req_logical && (req_dest == 32'hFFFF_FFFF);
      sender_oh   = N_AGENTS'(1) << req_sender;
      lookup_mask = phys_bcast ? '1 : hits;
      case (shorthand_e'(req_shorthand))
         SH_SELF:    raw_mask = present_v & sender_oh;
         SH_ALL:     raw_mask = present_v;
         SH_ALL_BUT: raw_mask = present_v & ~sender_oh;
         default:    raw_mask = lookup_mask;
      endcase
   end

   irq_dest_lowest #(.N_AGENTS(N_AGENTS), .LOWEST_IMPL(LOWEST_IMPL)) u_lowest (
      .mask_in  (raw_mask),
      .mask_out (low_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_mask <= req_lowest ? low_mask : raw_mask;
         end
      end
   end

endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
   parameter int N_AGENTS = 16,
   localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [31:0]         req_dest,
   input logic                req_logical,
   input logic [1:0]          req_shorthand,
   input logic [IDX_W-1:0]    req_sender,
   input logic                req_lowest,
   input logic                out_valid,
   input logic [N_AGENTS-1:0] out_mask
);

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R2
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R2
   AST_IDLE_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(out_mask)); // R2
   AST_PHYS_BCAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_shorthand == 2'd0 && !req_logical &&
       req_dest == 32'hFFFF_FFFF && !req_lowest) |=> (&out_mask)); // R3
   AST_SELF_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_shorthand == 2'd1) |=> ($countones(out_mask) <= 1)); // R10
   AST_SENDER_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_shorthand == 2'd3) |=> (out_mask[$past(req_sender)] == 1'b0)); // R10
   AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_lowest) |=> $onehot0(out_mask)); // R11

endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_dest      (req_dest),
   .req_logical   (req_logical),
   .req_shorthand (req_shorthand),
   .req_sender    (req_sender),
   .req_lowest    (req_lowest),
   .out_valid     (out_valid),
   .out_mask      (out_mask)
);

// File: tb/irq_dest_resolver_tb.sv
module irq_dest_resolver_tb;

   localparam int N  = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [7:0]    cfg_phys_id = '0;
   logic [31:0]   cfg_ext_id = '0;
   logic [7:0]    cfg_log_id = '0;
   logic          cfg_cluster = 1'b0;
   logic          cfg_ext = 1'b0;
   logic          cfg_present = 1'b0;
   logic          req_valid = 1'b0;
   logic [31:0]   req_dest = '0;
   logic          req_logical = 1'b0;
   logic [1:0]    req_shorthand = '0;
   logic [IW-1:0] req_sender = '0;
   logic          req_lowest = 1'b0;
   logic          out_valid;
   logic [N-1:0]  out_mask;

   int checks = 0;
   int errors = 0;

   logic        m_present [N];
   logic        m_ext     [N];
   logic        m_cluster [N];
   logic [7:0]  m_phys    [N];
   logic [7:0]  m_log     [N];
   logic [31:0] m_extid   [N];

   always #5 clk = ~clk;

   irq_dest_resolver #(.N_AGENTS(N)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_phys_id(cfg_phys_id),
      .cfg_ext_id(cfg_ext_id), .cfg_log_id(cfg_log_id), .cfg_cluster(cfg_cluster),
      .cfg_ext(cfg_ext), .cfg_present(cfg_present),
      .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
      .req_shorthand(req_shorthand), .req_sender(req_sender), .req_lowest(req_lowest),
      .out_valid(out_valid), .out_mask(out_mask)
   );

   function automatic logic [N-1:0] expect_mask(logic [31:0] d, logic lg,
                                                 logic [1:0] sh, int snd, logic low);
      logic [N-1:0] m;
      logic [N-1:0] r;
      logic         hit;
      m = '0;
      for (int i = 0; i < N; i++) begin
         hit = 1'b0;
         case (sh)
            2'd1: hit = (i == snd);
            2'd2: hit = 1'b1;
            2'd3: hit = (i != snd);
            default: begin
               if (!lg) begin
                  if (m_ext[i]) hit = (m_extid[i] == d);
                  else hit = (m_phys[i] == d[7:0]) || (d == 32'd255);
               end else if (m_ext[i]) begin
                  hit = (d == 32'hFFFF_FFFF) ||
                        ((d >> 16) == (m_extid[i] >> 16) && ((d & m_extid[i] & 32'hFFFF) != 0));
               end else if (m_cluster[i]) begin
                  hit = ((d[7:4] == 4'hF) || (d[7:4] == m_log[i][7:4])) &&
                        ((d[3:0] & m_log[i][3:0]) != 0);
               end else begin
                  hit = (d[7:0] & m_log[i]) != 0;
               end
            end
         endcase
         m[i] = hit && m_present[i];
      end
      if (sh == 2'd0 && !lg && d == 32'hFFFF_FFFF) m = '1;
      if (low) begin
         r = '0;
         for (int i = N - 1; i >= 0; i--) if (m[i]) r = '0 | (N'(1) << i);
         m = r;
      end
      return m;
   endfunction

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_agent(int i, logic p, logic e, logic c, logic [7:0] ph,
                              logic [7:0] lo, logic [31:0] x);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(i); cfg_present = p; cfg_ext = e;
      cfg_cluster = c; cfg_phys_id = ph; cfg_log_id = lo; cfg_ext_id = x;
      @(negedge clk);
      cfg_we = 1'b0;
      m_present[i] = p; m_ext[i] = e; m_cluster[i] = c;
      m_phys[i] = ph; m_log[i] = lo; m_extid[i] = x;
   endtask

   task automatic do_req(string req, logic [31:0] d, logic lg, logic [1:0] sh,
                         int snd, logic low);
      logic [N-1:0] exp;
      exp = expect_mask(d, lg, sh, snd, low);
      @(negedge clk);
      req_valid = 1'b1; req_dest = d; req_logical = lg;
      req_shorthand = sh; req_sender = IW'(snd); req_lowest = low;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      check(req, out_mask, exp);
      check("R2 valid", N'(out_valid), N'(1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [N-1:0] held;
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid in reset", N'(out_valid), '0);
      check("R1 mask in reset", out_mask, '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < N; i++) begin
         logic [7:0]  lo;
         logic [31:0] x;
         if (i >= 12) x = {16'(i / 2), 16'(1 << (i - 12))};
         else x = {16'(i), 16'hFFFF};
         if (i % 2 == 1) lo = {4'(i / 4), 4'(1 << (i % 4))};
         else lo = 8'(1 << (i % 8));
         write_agent(i, !(i == 5 || i == 11), i >= 12, (i < 12) && (i % 2 == 1),
                     8'(i * 3 + 1), lo, x);
      end

      for (int lw = 0; lw < 2; lw++) begin
         for (int b = 0; b < 256; b++) begin
            do_req("R4 R5 R11 physical byte", 32'(b), 1'b0, 2'd0, 0, lw[0]);
            do_req("R8 R9 R11 logical byte", 32'(b), 1'b1, 2'd0, 0, lw[0]);
         end
         do_req("R3 physical all ones", 32'hFFFF_FFFF, 1'b0, 2'd0, 0, lw[0]);
         do_req("R6 logical all ones", 32'hFFFF_FFFF, 1'b1, 2'd0, 0, lw[0]);
      end

      for (int i = 0; i < N; i++) begin
         do_req("R4 extended identity", m_extid[i], 1'b0, 2'd0, 0, 1'b0);
      end
      for (int c = 0; c < 9; c++) begin
         for (int k = 0; k < 6; k++) begin
            logic [15:0] mm;
            mm = (k == 5) ? 16'hFFFF : ((k == 4) ? 16'h0000 : 16'(1 << k));
            do_req("R7 logical extended cluster", {16'(c), mm}, 1'b1, 2'd0, 0, 1'b0);
         end
      end

      for (int sh = 1; sh < 4; sh++) begin
         for (int s = 0; s < N; s++) begin
            do_req("R10 shorthand", 32'h0000_00FF, s[0], 2'(sh), s, 1'b0);
            do_req("R10 R11 shorthand lowest", 32'hFFFF_FFFF, 1'b0, 2'(sh), s, 1'b1);
         end
      end

      held = out_mask;
      @(negedge clk);
      req_dest = 32'h0000_0001; req_logical = 1'b0; req_shorthand = 2'd2;
      repeat (2) @(posedge clk);
      #1;
      check("R2 idle valid", N'(out_valid), '0);
      check("R2 idle mask hold", out_mask, held);

      // R12: write and request on the same edge sees the old entry
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'd3; cfg_present = 1'b1; cfg_ext = 1'b0;
      cfg_cluster = 1'b0; cfg_phys_id = 8'h77; cfg_log_id = 8'h00; cfg_ext_id = 32'h0;
      req_valid = 1'b1; req_dest = 32'h77; req_logical = 1'b0;
      req_shorthand = 2'd0; req_lowest = 1'b0;
      @(posedge clk);
      #1;
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R12 same edge old entry", out_mask, expect_mask(32'h77, 1'b0, 2'd0, 0, 1'b0));
      m_phys[3] = 8'h77; m_log[3] = 8'h00; m_cluster[3] = 1'b0; m_extid[3] = 32'h0;
      do_req("R12 later edge new entry", 32'h77, 1'b0, 2'd0, 0, 1'b0);
      check("R12 new entry bit", out_mask, N'(1) << 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule